// File: doc/BRIEF.md
# Prioritized CAN Transmit Buffer Scheduler

This block sits between software and a CAN frame transmitter and owns three transmit message slots. Software queues a slot by writing its request bit and gives each slot a two-bit priority. While the bus is busy, or while a frame is already in flight, requests only wait. The first cycle the bus is free and no frame is active, the block chooses among the waiting slots, launches the winner with a one-cycle start strobe, and holds that slot's index steady until the transmitter reports completion.

The transmitter answers with a done strobe and a two-bit result code. The scheduler then updates the slot's request bit and its sticky status flags. A success retires the request and may raise a per-slot interrupt pulse. A lost arbitration or an error leaves the request pending for another attempt. Software can withdraw a single slot, or arm a global cancel that sweeps every waiting slot and clears itself once nothing is queued. A withdrawal aimed at the slot on the wire is held back until the outcome of that attempt is known.

Top module: `txSched`

## Requirements
- R1: After reset all request, abort, lost-arbitration, error and interrupt outputs are 0, the global cancel is 0, and `txStart` is 0.
- R2: The slot launched is the one with the numerically largest priority among the waiting slots (3 is highest, 0 is lowest). On equal priority the lower slot index wins. The choice uses request and priority values as registered on the cycle `txStart` is issued, so a priority write that lands at least one cycle before launch is honoured.
- R3: `txStart` pulses for exactly one cycle, one clock after a cycle in which `busFree` is 1, no frame is active and at least one slot is eligible. `txIdx` holds the launched slot until its done. A waiting request never launches while `busFree` is 0.
- R4: A `reqSetV` pulse sets that slot's request bit and clears its abort, lost-arbitration and error flags on the next clock.
- R5: A done with result 00 clears the active slot's request bit. It raises that slot's `txIrq` for one cycle, one clock after done, only if its `ieV` bit is 1.
- R6: A done with result 01 (lost arbitration) sets the slot's lost-arbitration flag. A done with result 10 or 11 (error) sets its error flag. In both cases the request stays set and no interrupt is raised.
- R7: A `reqClrV` pulse on a waiting slot that is not active clears its request and sets its abort flag on the next clock, with no interrupt. A `reqClrV` pulse on a slot whose request is 0 has no effect.
- R8: An `abortAll` pulse sets `abortAllQ`. While `abortAllQ` is 1, every waiting slot that is not active is aborted as in R7. `abortAllQ` drops one clock after a cycle in which no request remains.
- R9: A withdrawal (R7 or R8) aimed at the active slot is deferred. If that attempt succeeds, R5 applies and no abort flag is set. If it fails, the request clears and the abort flag sets along with the R6 flag.
- R10: A done arriving while no frame is active changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqSetV | input | NUM_BUF | Per-slot request-set pulse |
| reqClrV | input | NUM_BUF | Per-slot withdraw pulse |
| priWrV | input | NUM_BUF | Per-slot priority write enable |
| priData | input | PRI_W | Priority value written by `priWrV` |
| ieV | input | NUM_BUF | Per-slot interrupt enable |
| abortAll | input | 1 | Pulse that arms the global cancel |
| busFree | input | 1 | Bus idle indication from the transmitter |
| txDone | input | 1 | Attempt finished strobe |
| txResult | input | 2 | Outcome with done: 00 ok, 01 lost arbitration, 10/11 error |
| txStart | output | 1 | One-cycle launch strobe |
| txIdx | output | IDX_W | Slot being transmitted |
| reqQ | output | NUM_BUF | Request bits |
| abtQ | output | NUM_BUF | Abort flags |
| larbQ | output | NUM_BUF | Lost-arbitration flags |
| errQ | output | NUM_BUF | Error flags |
| abortAllQ | output | 1 | Global cancel armed |
| txIrq | output | NUM_BUF | Per-slot transmit interrupt pulse |

## Verification
The bench builds the block at its defaults: three slots with a two-bit priority field. This places all four priority levels, three-way and two-way ties, and a withdrawal aimed at the in-flight slot while two other slots wait within a short directed run. A behavioural model tracks every output on every clock. Directed checks cover late priority changes, the deferred abort after both a success and a failure, the self-clearing global cancel, and a stray done.

// File: rtl/txSchedPkg.sv
package txSchedPkg;
  typedef enum logic [1:0] {
    RES_OK   = 2'b00,
    RES_LARB = 2'b01,
    RES_ERR  = 2'b10,
    RES_ERRX = 2'b11
  } txRes_e;

  typedef struct packed {
    logic   launch;
    logic   finish;
    logic   finAbort;
    txRes_e res;
  } schedStrb_t;
endpackage

// File: rtl/txSchedPick.sv
module txSchedPick #(
  parameter int NUM_BUF = 3,
  parameter int PRI_W   = 2,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_BUF-1:0]            elig,
  input  logic [NUM_BUF-1:0][PRI_W-1:0] pri,
  output logic                          any,
  output logic [IDX_W-1:0]              win
);
  logic [PRI_W-1:0] bestPri;

  always_comb begin
    any     = 1'b0;
    win     = '0;
    bestPri = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (elig[i] && (!any || pri[i] > bestPri)) begin
        any     = 1'b1;
        win     = IDX_W'(i);
        bestPri = pri[i];
      end
    end
  end
endmodule

// File: rtl/txSchedCtrl.sv
module txSchedCtrl
  import txSchedPkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int PRI_W   = 2,
  parameter int IDX_W   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_BUF-1:0]            reqQ,
  input  logic [NUM_BUF-1:0][PRI_W-1:0] priQ,
  input  logic                          abortAllQ,
  input  logic [NUM_BUF-1:0]            reqSetV,
  input  logic [NUM_BUF-1:0]            reqClrV,
  input  logic                          busFree,
  input  logic                          txDone,
  input  logic [1:0]                    txResult,
  output schedStrb_t                    strb,
  output logic [IDX_W-1:0]              actIdx,
  output logic                          active,
  output logic                          txStart
);
  logic [NUM_BUF-1:0] elig;
  logic               anyElig;
  logic [IDX_W-1:0]   pickIdx;
  logic               deferQ;
  logic               clrOnAct;
  logic               setOnAct;

  assign elig = reqQ & ~reqClrV & {NUM_BUF{~abortAllQ}};

  txSchedPick #(.NUM_BUF(NUM_BUF), .PRI_W(PRI_W), .IDX_W(IDX_W)) uPick (
    .elig (elig),
    .pri  (priQ),
    .any  (anyElig),
    .win  (pickIdx)
  );

  always_comb begin
    clrOnAct = 1'b0;
    setOnAct = 1'b0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (actIdx == IDX_W'(i)) begin
        clrOnAct = reqClrV[i];
        setOnAct = reqSetV[i];
      end
    end
  end

  always_comb begin
    strb.launch   = !active && busFree && anyElig;
    strb.finish   = active && txDone;
    strb.finAbort = deferQ || clrOnAct || abortAllQ;
    strb.res      = txRes_e'(txResult);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      actIdx  <= '0;
      txStart <= 1'b0;
      deferQ  <= 1'b0;
    end else begin
      txStart <= strb.launch;
      if (strb.launch) begin
        active <= 1'b1;
        actIdx <= pickIdx;
        deferQ <= 1'b0;
      end else if (strb.finish) begin
        active <= 1'b0;
        deferQ <= 1'b0;
      end else if (active) begin
        if (setOnAct)                    deferQ <= 1'b0;
        else if (clrOnAct || abortAllQ)  deferQ <= 1'b1;
      end
    end
  end

  // R3
  start_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> $past(busFree));

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  // R2
  start_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> reqQ[actIdx]);
endmodule

// File: rtl/txSchedDp.sv
module txSchedDp
  import txSchedPkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int PRI_W   = 2,
  parameter int IDX_W   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  schedStrb_t                    strb,
  input  logic [IDX_W-1:0]              actIdx,
  input  logic                          active,
  input  logic [NUM_BUF-1:0]            reqSetV,
  input  logic [NUM_BUF-1:0]            reqClrV,
  input  logic [NUM_BUF-1:0]            priWrV,
  input  logic [PRI_W-1:0]              priData,
  input  logic [NUM_BUF-1:0]            ieV,
  input  logic                          abortAll,
  output logic [NUM_BUF-1:0]            reqQ,
  output logic [NUM_BUF-1:0]            abtQ,
  output logic [NUM_BUF-1:0]            larbQ,
  output logic [NUM_BUF-1:0]            errQ,
  output logic [NUM_BUF-1:0][PRI_W-1:0] priQ,
  output logic                          abortAllQ,
  output logic [NUM_BUF-1:0]            txIrq
);
  for (genvar gi = 0; gi < NUM_BUF; gi++) begin : gBuf
    logic isAct;
    logic reqR, abtR, larbR, errR, irqR;
    logic reqN, abtN, larbN, errN, irqN;
    logic [PRI_W-1:0] priR;

    assign isAct = active && (actIdx == IDX_W'(gi));

    always_comb begin
      reqN  = reqR;
      abtN  = abtR;
      larbN = larbR;
      errN  = errR;
      irqN  = 1'b0;
      if (strb.finish && isAct) begin
        if (strb.res == RES_OK) begin
          reqN = 1'b0;
          irqN = ieV[gi];
        end else begin
          if (strb.res == RES_LARB) larbN = 1'b1;
          else                      errN  = 1'b1;
          if (strb.finAbort) begin
            reqN = 1'b0;
            abtN = 1'b1;
          end
        end
      end else if (reqR && !isAct && (reqClrV[gi] || abortAllQ)) begin
        reqN = 1'b0;
        abtN = 1'b1;
      end
      if (reqSetV[gi]) begin
        reqN  = 1'b1;
        abtN  = 1'b0;
        larbN = 1'b0;
        errN  = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqR  <= 1'b0;
        abtR  <= 1'b0;
        larbR <= 1'b0;
        errR  <= 1'b0;
        irqR  <= 1'b0;
        priR  <= '0;
      end else begin
        reqR  <= reqN;
        abtR  <= abtN;
        larbR <= larbN;
        errR  <= errN;
        irqR  <= irqN;
        if (priWrV[gi]) priR <= priData;
      end
    end

    assign reqQ[gi]  = reqR;
    assign abtQ[gi]  = abtR;
    assign larbQ[gi] = larbR;
    assign errQ[gi]  = errR;
    assign txIrq[gi] = irqR;
    assign priQ[gi]  = priR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              abortAllQ <= 1'b0;
    else if (abortAll)      abortAllQ <= 1'b1;
    else if (reqQ == '0)    abortAllQ <= 1'b0;
  end

  // R7
  abort_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqQ & abtQ) == '0);

  // R6
  fail_noirq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && strb.res != RES_OK) |=> (txIrq == '0));

  // R8
  cancel_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortAllQ && reqQ == '0 && !abortAll) |=> !abortAllQ);

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txIrq));
endmodule

// File: rtl/txSched.sv
module txSched
  import txSchedPkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int PRI_W   = 2,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUF-1:0] reqSetV,
  input  logic [NUM_BUF-1:0] reqClrV,
  input  logic [NUM_BUF-1:0] priWrV,
  input  logic [PRI_W-1:0]   priData,
  input  logic [NUM_BUF-1:0] ieV,
  input  logic               abortAll,
  input  logic               busFree,
  input  logic               txDone,
  input  logic [1:0]         txResult,
  output logic               txStart,
  output logic [IDX_W-1:0]   txIdx,
  output logic [NUM_BUF-1:0] reqQ,
  output logic [NUM_BUF-1:0] abtQ,
  output logic [NUM_BUF-1:0] larbQ,
  output logic [NUM_BUF-1:0] errQ,
  output logic               abortAllQ,
  output logic [NUM_BUF-1:0] txIrq
);
  schedStrb_t                    strb;
  logic                          active;
  logic [NUM_BUF-1:0][PRI_W-1:0] priQ;

  txSchedCtrl #(.NUM_BUF(NUM_BUF), .PRI_W(PRI_W), .IDX_W(IDX_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqQ      (reqQ),
    .priQ      (priQ),
    .abortAllQ (abortAllQ),
    .reqSetV   (reqSetV),
    .reqClrV   (reqClrV),
    .busFree   (busFree),
    .txDone    (txDone),
    .txResult  (txResult),
    .strb      (strb),
    .actIdx    (txIdx),
    .active    (active),
    .txStart   (txStart)
  );

  txSchedDp #(.NUM_BUF(NUM_BUF), .PRI_W(PRI_W), .IDX_W(IDX_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .actIdx    (txIdx),
    .active    (active),
    .reqSetV   (reqSetV),
    .reqClrV   (reqClrV),
    .priWrV    (priWrV),
    .priData   (priData),
    .ieV       (ieV),
    .abortAll  (abortAll),
    .reqQ      (reqQ),
    .abtQ      (abtQ),
    .larbQ     (larbQ),
    .errQ      (errQ),
    .priQ      (priQ),
    .abortAllQ (abortAllQ),
    .txIrq     (txIrq)
  );
endmodule

// File: tb/sim_txSched.sv
module sim_txSched;
  localparam int NB = 3;
  localparam int PW = 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN = 1'b0;
  logic [NB-1:0] reqSetV = '0, reqClrV = '0, priWrV = '0, ieV = '0;
  logic [PW-1:0] priData = '0;
  logic          abortAll = 1'b0, busFree = 1'b0, txDone = 1'b0;
  logic [1:0]    txResult = 2'b00;
  logic          txStart, abortAllQ;
  logic [IW-1:0] txIdx;
  logic [NB-1:0] reqQ, abtQ, larbQ, errQ, txIrq;

  txSched #(.NUM_BUF(NB), .PRI_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .reqSetV(reqSetV), .reqClrV(reqClrV),
    .priWrV(priWrV), .priData(priData), .ieV(ieV), .abortAll(abortAll),
    .busFree(busFree), .txDone(txDone), .txResult(txResult),
    .txStart(txStart), .txIdx(txIdx), .reqQ(reqQ), .abtQ(abtQ),
    .larbQ(larbQ), .errQ(errQ), .abortAllQ(abortAllQ), .txIrq(txIrq)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [NB-1:0] mReq, mAbt, mLarb, mErr, mIrq;
  int            mPri [NB];
  bit            mAct, mDefer, mAbAll, mStart;
  int            mIdx;

  always @(posedge clk) begin
    if (!rstN) begin
      mReq = '0; mAbt = '0; mLarb = '0; mErr = '0; mIrq = '0;
      for (int i = 0; i < NB; i++) mPri[i] = 0;
      mAct = 0; mDefer = 0; mAbAll = 0; mStart = 0; mIdx = 0;
    end else begin
      logic [NB-1:0] nReq, nAbt, nLarb, nErr, nIrq;
      int  sel, bp;
      bit  launch, finish, fa, nDefer, nAbAll;
      nReq = mReq; nAbt = mAbt; nLarb = mLarb; nErr = mErr; nIrq = '0;
      sel = -1; bp = -1;
      for (int i = 0; i < NB; i++)
        if (mReq[i] && !reqClrV[i] && !mAbAll && mPri[i] > bp) begin
          sel = i; bp = mPri[i];
        end
      launch = !mAct && busFree && sel >= 0;
      finish = mAct && txDone;
      fa = mDefer || reqClrV[mIdx] || mAbAll;
      for (int i = 0; i < NB; i++) begin
        if (finish && i == mIdx) begin
          if (txResult == 2'b00) begin
            nReq[i] = 0; nIrq[i] = ieV[i];
          end else begin
            if (txResult == 2'b01) nLarb[i] = 1; else nErr[i] = 1;
            if (fa) begin nReq[i] = 0; nAbt[i] = 1; end
          end
        end else if (mReq[i] && !(mAct && i == mIdx) && (reqClrV[i] || mAbAll)) begin
          nReq[i] = 0; nAbt[i] = 1;
        end
        if (reqSetV[i]) begin
          nReq[i] = 1; nAbt[i] = 0; nLarb[i] = 0; nErr[i] = 0;
        end
        if (priWrV[i]) mPri[i] = int'(priData);
      end
      nDefer = mDefer;
      if (launch || finish) nDefer = 0;
      else if (mAct && reqSetV[mIdx]) nDefer = 0;
      else if (mAct && (reqClrV[mIdx] || mAbAll)) nDefer = 1;
      nAbAll = abortAll ? 1'b1 : (mReq == '0 ? 1'b0 : mAbAll);
      if (launch) begin mAct = 1; mIdx = sel; end
      else if (finish) mAct = 0;
      mStart = launch;
      mReq = nReq; mAbt = nAbt; mLarb = nLarb; mErr = nErr; mIrq = nIrq;
      mDefer = nDefer; mAbAll = nAbAll;
    end
    #1;
    if (rstN) begin
      chk("R5 model reqQ", int'(reqQ), int'(mReq));
      chk("R7 model abtQ", int'(abtQ), int'(mAbt));
      chk("R6 model larbQ", int'(larbQ), int'(mLarb));
      chk("R6 model errQ", int'(errQ), int'(mErr));
      chk("R8 model abortAllQ", int'(abortAllQ), int'(mAbAll));
      chk("R5 model txIrq", int'(txIrq), int'(mIrq));
      chk("R3 model txStart", int'(txStart), int'(mStart));
      if (mAct) chk("R2 model txIdx", int'(txIdx), mIdx);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic setReq(logic [NB-1:0] v);
    reqSetV = v; step(); reqSetV = '0;
  endtask

  task automatic clrReq(logic [NB-1:0] v);
    reqClrV = v; step(); reqClrV = '0;
  endtask

  task automatic wrPri(logic [NB-1:0] v, logic [PW-1:0] p);
    priWrV = v; priData = p; step(); priWrV = '0;
  endtask

  task automatic finishTx(logic [1:0] r);
    txDone = 1'b1; txResult = r; step(); txDone = 1'b0; txResult = 2'b00;
  endtask

  task automatic launchExp(int idx, string tag);
    busFree = 1'b1; step(); busFree = 1'b0;
    chk({tag, " txStart"}, int'(txStart), 1);
    chk({tag, " txIdx"}, int'(txIdx), idx);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL R3 watchdog expired got 1 exp 0");
    summary();
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    // R1 reset state
    chk("R1 reqQ", int'(reqQ), 0);
    chk("R1 abtQ", int'(abtQ | larbQ | errQ), 0);
    chk("R1 txStart", int'(txStart), 0);
    chk("R1 abortAllQ", int'(abortAllQ), 0);
    chk("R1 txIrq", int'(txIrq), 0);

    ieV = 3'b111;
    wrPri(3'b001, 2'd1);
    wrPri(3'b110, 2'd3);
    setReq(3'b111);
    step(2);
    // R4 queued only, R3 no launch while bus busy
    chk("R4 reqQ queued", int'(reqQ), 7);
    chk("R3 no start when busy", int'(txStart), 0);

    // R2 tie between slots 1 and 2 at priority 3
    launchExp(1, "R2 tie");
    step();
    chk("R3 one-cycle pulse", int'(txStart), 0);
    chk("R3 idx held", int'(txIdx), 1);

    finishTx(2'b00);
    chk("R5 req cleared", int'(reqQ), 3'b101);
    chk("R5 irq pulse", int'(txIrq), 3'b010);
    step();
    chk("R5 irq one cycle", int'(txIrq), 0);

    // R2 late priority change before launch
    wrPri(3'b001, 2'd3);
    launchExp(0, "R2 late priority");

    finishTx(2'b01);
    chk("R6 larb flag", int'(larbQ), 3'b001);
    chk("R6 req kept after larb", int'(reqQ), 3'b101);
    chk("R6 no irq on larb", int'(txIrq), 0);

    launchExp(0, "R6 retry");
    finishTx(2'b10);
    chk("R6 err flag", int'(errQ), 3'b001);
    chk("R6 req kept after err", int'(reqQ), 3'b101);
    chk("R6 no irq on err", int'(txIrq), 0);

    setReq(3'b001);
    chk("R4 flags cleared", int'(larbQ | errQ), 0);

    clrReq(3'b100);
    chk("R7 abort req", int'(reqQ), 3'b001);
    chk("R7 abort flag", int'(abtQ), 3'b100);
    chk("R7 no irq", int'(txIrq), 0);
    clrReq(3'b100);
    chk("R7 ignored req", int'(reqQ), 3'b001);
    chk("R7 ignored abt", int'(abtQ), 3'b100);

    // R9 deferred abort, success path
    launchExp(0, "R9 launch a");
    clrReq(3'b001);
    chk("R9 deferred req", int'(reqQ), 3'b001);
    chk("R9 deferred abt", int'(abtQ), 3'b100);
    finishTx(2'b00);
    chk("R9 success req", int'(reqQ), 0);
    chk("R9 success abt", int'(abtQ), 3'b100);
    chk("R9 success irq", int'(txIrq), 3'b001);

    // R9 deferred abort, error path
    setReq(3'b001);
    launchExp(0, "R9 launch b");
    clrReq(3'b001);
    finishTx(2'b10);
    chk("R9 fail req", int'(reqQ), 0);
    chk("R9 fail abt", int'(abtQ), 3'b101);
    chk("R9 fail err", int'(errQ), 3'b001);

    // R8 global cancel
    setReq(3'b111);
    launchExp(0, "R8 launch");
    abortAll = 1'b1; step(); abortAll = 1'b0;
    chk("R8 armed", int'(abortAllQ), 1);
    step();
    chk("R8 sweep req", int'(reqQ), 3'b001);
    chk("R8 sweep abt", int'(abtQ), 3'b110);
    finishTx(2'b01);
    chk("R8 active aborted", int'(abtQ), 3'b111);
    chk("R8 active larb", int'(larbQ), 3'b001);
    chk("R8 still armed", int'(abortAllQ), 1);
    step();
    chk("R8 self clear", int'(abortAllQ), 0);

    // R10 stray done
    finishTx(2'b00);
    chk("R10 req", int'(reqQ), 0);
    chk("R10 irq", int'(txIrq), 0);
    chk("R10 abt", int'(abtQ), 3'b111);

    // R5 interrupt disabled
    ieV = 3'b000;
    setReq(3'b010);
    launchExp(1, "R5 ie off");
    finishTx(2'b00);
    chk("R5 ie off irq", int'(txIrq), 0);
    chk("R5 ie off req", int'(reqQ), 0);

    // R2 full ordering: 2 over 1 over 0
    ieV = 3'b111;
    wrPri(3'b001, 2'd0);
    wrPri(3'b010, 2'd2);
    wrPri(3'b100, 2'd1);
    setReq(3'b111);
    launchExp(1, "R2 order first");
    finishTx(2'b00);
    launchExp(2, "R2 order second");
    finishTx(2'b00);
    launchExp(0, "R2 order lowest");
    finishTx(2'b00);
    chk("R2 all done", int'(reqQ), 0);

    step(3);
    summary();
  end
endmodule